// File: doc/BRIEF.md
# MMU Control and Fault Register Bank

This block holds the software-visible state that steers a memory management unit. Its registers hold the translation enable and the other control bits, the base address of the translation table, a two-bit access setting for each protection domain, one fault status register for instruction fetches, one for data accesses, and a fault address register. Software reaches them through a single-cycle register port: a write lands on the next clock edge, and a read returns data combinationally in the same cycle.

The translation path signals an abort with a one-cycle strobe, one strobe for the instruction side and one for the data side. With the strobe it gives the domain number, a four-bit fault code and the virtual address. The bank stores this fault information. It also decodes the access setting of a domain number that the translation path supplies, and reports whether that domain faults, is a client that still needs a page permission check, or is a manager that skips the check. The table walker and the ordering of fault causes are outside this block.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset every register reads zero. This includes the translation enable output, which is clear.
- R2: Address 0 is the control register. Bit 0 enables translation, bit 1 enables alignment checks, bit 2 is protection bit S and bit 3 is protection bit R. Each bit drives its own output. Bits 31:4 read as zero.
- R3: Address 1 is the translation table base. Only bits 31:14 are stored, and bits 13:0 always read as zero, so the base is always 16 KB aligned. The stored value drives the `tbl_base` output.
- R4: Address 2 is the domain access register. It is 32 bits wide, and domain n uses bits 2n+1:2n.
- R5: For the domain on `chk_dom`, the field value 00 or 10 raises `chk_fault`, 01 raises `chk_client` and 11 raises `chk_manager`. Exactly one of the three is high. All three follow `chk_dom` in the same cycle.
- R6: When `iabt` is high at a clock edge, the instruction status register at address 3 takes `{abt_dom, abt_code}` in bits 7:4 and 3:0. The value is visible after that edge.
- R7: When `dabt` is high at a clock edge, the data status register at address 4 takes `{abt_dom, abt_code}`, and the fault address register at address 5 takes all 32 bits of `abt_va`. Both updates happen at the same edge.
- R8: An instruction abort alone leaves the data status register and the fault address register unchanged. A data abort alone leaves the instruction status register unchanged.
- R9: Software may write the two status registers and the fault address register. Status bits 31:8 read as zero. If a write and an abort capture reach the same register at the same edge, the capture wins.
- R10: Addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| iabt | input | 1 | Instruction abort capture strobe |
| dabt | input | 1 | Data abort capture strobe |
| abt_dom | input | 4 | Domain of the aborted access |
| abt_code | input | 4 | Fault type code of the aborted access |
| abt_va | input | 32 | Virtual address of the aborted access |
| chk_dom | input | 4 | Domain to look up |
| chk_fault | output | 1 | Looked-up domain faults (00 or 10) |
| chk_client | output | 1 | Looked-up domain is a client (01) |
| chk_manager | output | 1 | Looked-up domain is a manager (11) |
| xlate_en | output | 1 | Translation enable |
| align_chk_en | output | 1 | Alignment check enable |
| prot_s | output | 1 | Protection scheme bit S |
| prot_r | output | 1 | Protection scheme bit R |
| tbl_base | output | 32 | Table base, low 14 bits zero |

## Verification
Register writes and abort captures take effect at the first rising edge at which they are presented. Read data and the domain lookup are combinational and valid in the same cycle. The bench therefore drives a whole cycle of stimulus at a falling edge and lets exactly one rising edge pass. At the next falling edge, with the strobes and write enable low, it sweeps all eight read addresses and all sixteen lookup domains and compares them with a bench model. The model applies the writes and captures for that edge, with the capture taking precedence.

// File: rtl/mmu_ctl_pkg.sv
// Package: shared register indices and domain access encodings for the MMU
// control register bank. Assumes a 3-bit register index space.
package mmu_ctl_pkg;

    typedef enum logic [2:0] {
        RA_CTL  = 3'd0,
        RA_TBL  = 3'd1,
        RA_DOM  = 3'd2,
        RA_IFS  = 3'd3,
        RA_DFS  = 3'd4,
        RA_FADR = 3'd5
    } reg_idx_e;

    typedef enum logic [1:0] {
        DOM_NOACC  = 2'b00,
        DOM_CLIENT = 2'b01,
        DOM_RSVD   = 2'b10,
        DOM_MGR    = 2'b11
    } dom_acc_e;

    localparam int CTL_BITS = 4;

endpackage

// File: rtl/mmu_ctl_cfg.sv
// Module: configuration registers (control, table base, domain access).
// Assumes writes are single-cycle strobes. The table base keeps only bits at
// and above ALIGN_LSB. Synchronous active-low reset clears every register.
module mmu_ctl_cfg
    import mmu_ctl_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ALIGN_LSB = 14,
    parameter int DAC_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [2:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [CTL_BITS-1:0] ctl_q,
    output logic [DATA_W-1:0]   tbl_q,
    output logic [DAC_W-1:0]    dom_q
);
    localparam int BASE_W = DATA_W - ALIGN_LSB;

    logic [BASE_W-1:0] base_hi;

    // Register updates from the software write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            base_hi <= '0;
            dom_q   <= '0;
        end else if (we) begin
            if (addr == RA_CTL) ctl_q   <= wdata[CTL_BITS-1:0];
            if (addr == RA_TBL) base_hi <= wdata[DATA_W-1:ALIGN_LSB];
            if (addr == RA_DOM) dom_q   <= wdata[DAC_W-1:0];
        end
    end

    // Aligned base: the dropped low bits are tied to zero.
    always_comb tbl_q = {base_hi, {ALIGN_LSB{1'b0}}};

endmodule

// File: rtl/mmu_ctl_fault.sv
// Module: fault capture registers (instruction status, data status, fault
// address). Assumes abort strobes are one cycle wide. A capture overrides a
// software write to the same register in the same cycle.
module mmu_ctl_fault
    import mmu_ctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DOM_W  = 4,
    parameter int CODE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [2:0]                addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      iabt,
    input  logic                      dabt,
    input  logic [DOM_W-1:0]          abt_dom,
    input  logic [CODE_W-1:0]         abt_code,
    input  logic [DATA_W-1:0]         abt_va,
    output logic [DOM_W+CODE_W-1:0]   ifs_q,
    output logic [DOM_W+CODE_W-1:0]   dfs_q,
    output logic [DATA_W-1:0]         fadr_q
);
    localparam int FS_W = DOM_W + CODE_W;

    logic [FS_W-1:0] cap;

    // Packed status word: domain above the fault code.
    always_comb cap = {abt_dom, abt_code};

    // Instruction-side status: capture wins over the software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ifs_q <= '0;
        else if (iabt)                    ifs_q <= cap;
        else if (we && addr == RA_IFS)    ifs_q <= wdata[FS_W-1:0];
    end

    // Data-side status and fault address capture together on a data abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dfs_q  <= '0;
            fadr_q <= '0;
        end else if (dabt) begin
            dfs_q  <= cap;
            fadr_q <= abt_va;
        end else if (we) begin
            if (addr == RA_DFS)  dfs_q  <= wdata[FS_W-1:0];
            if (addr == RA_FADR) fadr_q <= wdata;
        end
    end

endmodule

// File: rtl/mmu_ctl_domchk.sv
// Module: combinational domain access lookup. Assumes NUM_DOM two-bit fields
// packed from bit 0 upward. 00 and the reserved 10 both report a fault.
module mmu_ctl_domchk
    import mmu_ctl_pkg::*;
#(
    parameter int NUM_DOM = 16,
    parameter int DOM_W   = 4
) (
    input  logic [2*NUM_DOM-1:0] dom_reg,
    input  logic [DOM_W-1:0]     dom_sel,
    output logic                 is_fault,
    output logic                 is_client,
    output logic                 is_manager
);
    dom_acc_e fld;

    // Field selection and decode.
    always_comb begin
        fld        = dom_acc_e'(dom_reg[2*dom_sel +: 2]);
        is_client  = (fld == DOM_CLIENT);
        is_manager = (fld == DOM_MGR);
        is_fault   = (fld == DOM_NOACC) || (fld == DOM_RSVD);
    end

endmodule

// File: rtl/mmu_ctl_regs.sv
// Module: top of the MMU control and fault register bank. Joins the
// configuration registers, the fault capture and the domain lookup, and
// drives the combinational read mux. Assumes a single-cycle register port.
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int NUM_DOM   = 16,
    parameter int CODE_W    = 4,
    parameter int ALIGN_LSB = 14,
    localparam int DATA_W   = 32,
    localparam int DOM_W    = $clog2(NUM_DOM),
    localparam int FS_W     = DOM_W + CODE_W,
    localparam int DAC_W    = 2 * NUM_DOM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              iabt,
    input  logic              dabt,
    input  logic [DOM_W-1:0]  abt_dom,
    input  logic [CODE_W-1:0] abt_code,
    input  logic [DATA_W-1:0] abt_va,
    input  logic [DOM_W-1:0]  chk_dom,
    output logic              chk_fault,
    output logic              chk_client,
    output logic              chk_manager,
    output logic              xlate_en,
    output logic              align_chk_en,
    output logic              prot_s,
    output logic              prot_r,
    output logic [DATA_W-1:0] tbl_base
);
    logic [CTL_BITS-1:0] ctl_q;
    logic [DAC_W-1:0]    dom_q;
    logic [FS_W-1:0]     ifs_q;
    logic [FS_W-1:0]     dfs_q;
    logic [DATA_W-1:0]   fadr_q;

    mmu_ctl_cfg #(
        .DATA_W    (DATA_W),
        .ALIGN_LSB (ALIGN_LSB),
        .DAC_W     (DAC_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctl_q (ctl_q),
        .tbl_q (tbl_base),
        .dom_q (dom_q)
    );

    mmu_ctl_fault #(
        .DATA_W (DATA_W),
        .DOM_W  (DOM_W),
        .CODE_W (CODE_W)
    ) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .iabt     (iabt),
        .dabt     (dabt),
        .abt_dom  (abt_dom),
        .abt_code (abt_code),
        .abt_va   (abt_va),
        .ifs_q    (ifs_q),
        .dfs_q    (dfs_q),
        .fadr_q   (fadr_q)
    );

    mmu_ctl_domchk #(
        .NUM_DOM (NUM_DOM),
        .DOM_W   (DOM_W)
    ) u_domchk (
        .dom_reg    (dom_q),
        .dom_sel    (chk_dom),
        .is_fault   (chk_fault),
        .is_client  (chk_client),
        .is_manager (chk_manager)
    );

    // Control bits fanned out to their own outputs.
    always_comb begin
        xlate_en     = ctl_q[0];
        align_chk_en = ctl_q[1];
        prot_s       = ctl_q[2];
        prot_r       = ctl_q[3];
    end

    // Read mux; unmapped indices and unused upper bits return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTL:  reg_rdata[CTL_BITS-1:0] = ctl_q;
            RA_TBL:  reg_rdata               = tbl_base;
            RA_DOM:  reg_rdata[DAC_W-1:0]    = dom_q;
            RA_IFS:  reg_rdata[FS_W-1:0]     = ifs_q;
            RA_DFS:  reg_rdata[FS_W-1:0]     = dfs_q;
            RA_FADR: reg_rdata               = fadr_q;
            default: reg_rdata               = '0;
        endcase
    end

endmodule

// File: rtl/mmu_ctl_regs_chk.sv
// Module: assertion checker for mmu_ctl_regs, attached with bind. Observes
// ports and the fault registers between the capture and read logic.
module mmu_ctl_regs_chk #(
    parameter int DOM_W  = 4,
    parameter int CODE_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_we,
    input logic [2:0]              reg_addr,
    input logic [31:0]             reg_wdata,
    input logic                    iabt,
    input logic                    dabt,
    input logic [DOM_W-1:0]        abt_dom,
    input logic [CODE_W-1:0]       abt_code,
    input logic [31:0]             abt_va,
    input logic                    chk_fault,
    input logic                    chk_client,
    input logic                    chk_manager,
    input logic                    xlate_en,
    input logic [31:0]             tbl_base,
    input logic [DOM_W+CODE_W-1:0] ifs_q,
    input logic [DOM_W+CODE_W-1:0] dfs_q,
    input logic [31:0]             fadr_q
);
    // R1: a reset edge leaves translation off and the fault state cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!xlate_en && tbl_base == '0 && ifs_q == '0 && dfs_q == '0 && fadr_q == '0));

    // R3: a base write keeps the upper bits and zeroes the low ones.
    p_base_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd1) |=>
        (tbl_base[13:0] == '0 && tbl_base[31:14] == $past(reg_wdata[31:14])));

    // R5: exactly one lookup result is active.
    p_lookup_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({chk_fault, chk_client, chk_manager}) == 1);

    // R6: an instruction abort loads its status register.
    p_ifs_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iabt |=> ifs_q == $past({abt_dom, abt_code}));

    // R7: a data abort loads the data status register.
    p_dfs_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dabt |=> dfs_q == $past({abt_dom, abt_code}));

    // R7: a data abort loads the fault address in the same edge.
    p_fadr_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dabt |=> fadr_q == $past(abt_va));

    // R8: an instruction abort alone does not move the fault address.
    p_iabt_keeps_fadr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iabt && !dabt && !(reg_we && reg_addr == 3'd5)) |=> $stable(fadr_q));

endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(
    .DOM_W  (DOM_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .iabt        (iabt),
    .dabt        (dabt),
    .abt_dom     (abt_dom),
    .abt_code    (abt_code),
    .abt_va      (abt_va),
    .chk_fault   (chk_fault),
    .chk_client  (chk_client),
    .chk_manager (chk_manager),
    .xlate_en    (xlate_en),
    .tbl_base    (tbl_base),
    .ifs_q       (ifs_q),
    .dfs_q       (dfs_q),
    .fadr_q      (fadr_q)
);

// File: tb/mmu_ctl_regs_tb.sv
`timescale 1ns/100ps
module mmu_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        iabt, dabt;
    logic [3:0]  abt_dom, abt_code, chk_dom;
    logic [31:0] abt_va;
    logic        chk_fault, chk_client, chk_manager;
    logic        xlate_en, align_chk_en, prot_s, prot_r;
    logic [31:0] tbl_base;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Bench model of the register contents.
    logic [3:0]  m_ctl;
    logic [31:0] m_tbl, m_dom, m_fadr;
    logic [7:0]  m_ifs, m_dfs;

    always #4 clk = ~clk;   // 125 MHz

    mmu_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iabt(iabt), .dabt(dabt),
        .abt_dom(abt_dom), .abt_code(abt_code), .abt_va(abt_va), .chk_dom(chk_dom),
        .chk_fault(chk_fault), .chk_client(chk_client), .chk_manager(chk_manager),
        .xlate_en(xlate_en), .align_chk_en(align_chk_en), .prot_s(prot_s),
        .prot_r(prot_r), .tbl_base(tbl_base)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {28'd0, m_ctl};
            3'd1: return m_tbl;
            3'd2: return m_dom;
            3'd3: return {24'd0, m_ifs};
            3'd4: return {24'd0, m_dfs};
            3'd5: return m_fadr;
            default: return 32'd0;
        endcase
    endfunction

    // Lookup result packed as {fault, client, manager}.
    function automatic logic [2:0] exp_lookup(input logic [3:0] d);
        logic [1:0] f;
        f = m_dom[2*d +: 2];
        case (f)
            2'b01:   return 3'b010;
            2'b11:   return 3'b001;
            default: return 3'b100;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    // One clock of stimulus, then the model applies the same edge.
    task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                        input logic ia, input logic da, input logic [3:0] dm,
                        input logic [3:0] cd, input logic [31:0] va);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        iabt = ia; dabt = da; abt_dom = dm; abt_code = cd; abt_va = va;
        @(posedge clk);
        if (we) begin
            case (a)
                3'd0: m_ctl  = wd[3:0];
                3'd1: m_tbl  = {wd[31:14], 14'd0};
                3'd2: m_dom  = wd;
                3'd3: m_ifs  = wd[7:0];
                3'd4: m_dfs  = wd[7:0];
                3'd5: m_fadr = wd;
                default: ;
            endcase
        end
        // R9: capture overrides a same-edge write.
        if (ia) m_ifs = {dm, cd};
        if (da) begin m_dfs = {dm, cd}; m_fadr = va; end
    endtask

    // Idle the inputs and compare every readable item against the model.
    task automatic check_all();
        @(negedge clk);
        reg_we = 1'b0; iabt = 1'b0; dabt = 1'b0;
        for (int a = 0; a < 8; a++) begin
            reg_addr = a[2:0];
            #0.1;
            chk(req_of(a[2:0]), reg_rdata, exp_rd(a[2:0]));
        end
        chk("R2", {28'd0, prot_r, prot_s, align_chk_en, xlate_en}, {28'd0, m_ctl});
        chk("R3", tbl_base, m_tbl);
        for (int d = 0; d < 16; d++) begin
            chk_dom = d[3:0];
            #0.1;
            chk("R5", {29'd0, chk_fault, chk_client, chk_manager}, {29'd0, exp_lookup(d[3:0])});
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        iabt = 1'b0; dabt = 1'b0; abt_dom = '0; abt_code = '0; abt_va = '0; chk_dom = '0;
        m_ctl = '0; m_tbl = '0; m_dom = '0; m_fadr = '0; m_ifs = '0; m_dfs = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        for (int a = 0; a < 8; a++) begin
            reg_addr = a[2:0];
            #0.1;
            chk("R1", reg_rdata, 32'd0);
        end
        chk("R1", {31'd0, xlate_en}, 32'd0);
        rst_n = 1'b1;

        // R2: control bits, upper bits dropped.
        step(1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); check_all();
        step(1, 3'd0, 32'h0000_0005, 0, 0, 0, 0, 0); check_all();
        // R3: alignment mask on the table base.
        step(1, 3'd1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); check_all();
        chk("R3", tbl_base, 32'hFFFF_C000);
        // R4 / R5: every field encoding across the domains.
        step(1, 3'd2, 32'hE4E4_1B1B, 0, 0, 0, 0, 0); check_all();
        // R6 / R8: instruction abort only.
        step(0, 3'd0, 0, 1, 0, 4'hA, 4'h5, 32'hDEAD_BEEF); check_all();
        chk("R8", {24'd0, m_dfs}, 32'd0);
        // R7: data abort captures status and address together.
        step(0, 3'd0, 0, 0, 1, 4'h3, 4'hD, 32'h1234_5678); check_all();
        // R9: write and capture collide on the same registers.
        step(1, 3'd4, 32'h0000_00FF, 0, 1, 4'h6, 4'h1, 32'hCAFE_0001); check_all();
        step(1, 3'd5, 32'h0BAD_0BAD, 0, 1, 4'h7, 4'h2, 32'hCAFE_0002); check_all();
        step(1, 3'd3, 32'h0000_0077, 1, 0, 4'h8, 4'h9, 32'h0); check_all();
        // R9: plain status write, upper bits dropped.
        step(1, 3'd3, 32'hFFFF_FF3C, 0, 0, 0, 0, 0); check_all();
        // R10: writes to unmapped indices change nothing.
        step(1, 3'd6, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); check_all();
        step(1, 3'd7, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); check_all();

        // Random mix of writes and aborts.
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 2) == 0, 3'($urandom % 8), $urandom,
                 ($urandom % 4) == 0, ($urandom % 4) == 0,
                 4'($urandom), 4'($urandom), $urandom);
            check_all();
        end

        // R1: reset again after activity.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        m_ctl = '0; m_tbl = '0; m_dom = '0; m_fadr = '0; m_ifs = '0; m_dfs = '0;
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            reg_addr = a[2:0];
            #0.1;
            chk("R1", reg_rdata, 32'd0);
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule